// File: doc/BRIEF.md
# Bunch Crossing Counter and Timing Command Decoder

This block keeps the chip's notion of which bunch crossing is in progress and acts on the fast timing commands that arrive from the timing system. A 12-bit counter steps once per bunch clock and its low bits form the timestamp attached to every hit packet. When a bunch-count reset command arrives, the block first compares the running count with a configured expected value. On a disagreement it keeps the count it saw and bumps a saturating error tally. It then reloads the counter with a configured offset.

The other four commands each produce their own output. A front-end reset starts a fixed-length clear of the data buffers and leaves configuration and counters alone. A sync command triggers the serialisers to transmit a configured pattern. A snapshot command freezes the counter, error tally and last bad count together so they can be read out later. A calibration command produces a one-cycle test-pulse strobe. Command strobes arrive already decoded, one bit per command and at most one high in a cycle. The configuration values are plain inputs held by an external register bank.

Top module: `bxt_fast_ctrl`

## Requirements
- R1: With no bunch-count reset, `bx_count` advances by exactly one on every clock edge, wrapping from 4095 to 0.
- R2: A bunch-count reset loads `cfg_offset` into `bx_count`, visible in the cycle after the command.
- R3: If `bx_count` differs from `cfg_expected` when a bunch-count reset arrives, `err_count` rises by one and `err_last_bx` takes the count present at the command, both visible in the next cycle.
- R4: If `bx_count` equals `cfg_expected` when a bunch-count reset arrives, `err_count` and `err_last_bx` keep their values.
- R5: `err_count` saturates at all ones: further mismatches leave it at its maximum.
- R6: `timestamp` equals bits 8..0 of `bx_count` in the same cycle.
- R7: After a front-end reset command, `buf_clear` and `clear_busy` go high in the next cycle and stay high for exactly 64 cycles. A new front-end reset during a clear restarts the 64 cycles. A front-end reset changes neither `bx_count` nor `err_count`.
- R8: A sync command raises `sync_send` for exactly one cycle, starting in the next cycle. `sync_word` then holds the `cfg_sync_word` value present at the command until the next sync command.
- R9: A snapshot command copies `bx_count`, `err_count` and `err_last_bx` as they are at the command into `snap_bx`, `snap_err` and `snap_last_bx`. These hold until the next snapshot, regardless of later counter activity.
- R10: A calibration command raises `cal_pulse` for exactly one cycle, starting in the next cycle.
- R11: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_fe_rst | input | 1 | Front-end reset strobe |
| cmd_bc_rst | input | 1 | Bunch-count reset strobe |
| cmd_sync | input | 1 | Sync pattern strobe |
| cmd_snap | input | 1 | Snapshot strobe |
| cmd_cal | input | 1 | Calibration pulse strobe |
| cfg_offset | input | 12 | Value loaded on bunch-count reset |
| cfg_expected | input | 12 | Count expected when bunch-count reset arrives |
| cfg_sync_word | input | 32 | Pattern for the serialisers on sync |
| bx_count | output | 12 | Running bunch crossing count |
| timestamp | output | 9 | Hit timestamp, low bits of the count |
| buf_clear | output | 1 | Data buffer clear request |
| clear_busy | output | 1 | High while a clear is in progress |
| sync_send | output | 1 | One-cycle request to send the sync pattern |
| sync_word | output | 32 | Pattern captured at the last sync |
| cal_pulse | output | 1 | One-cycle test-pulse strobe |
| err_count | output | ERR_W (8) | Saturating count of misaligned bunch-count resets |
| err_last_bx | output | 12 | Count seen at the last misaligned reset |
| snap_bx | output | 12 | Snapshot of the count |
| snap_err | output | ERR_W (8) | Snapshot of the error tally |
| snap_last_bx | output | 12 | Snapshot of the last bad count |

## Verification
The bench builds the block with a 3-bit error tally, so that saturation is reached after seven misaligned resets instead of 255 (R5). The counter width, timestamp width and 64-cycle clear length keep their defaults. This keeps the full 4096-count wrap and the exact clear length inside a short run. An offset just below the top of the count range reaches both the counter wrap and a timestamp wrap within a few cycles. A second front-end reset issued partway through a clear exercises the restart.

// File: rtl/bxt_pkg.sv
package bxt_pkg;
  localparam int BXT_BX_W      = 12;
  localparam int BXT_TS_W      = 9;
  localparam int BXT_ERR_W     = 8;
  localparam int BXT_CLR_LEN   = 64;
  localparam int BXT_SYNC_W    = 32;

  typedef enum logic [2:0] {
    BXT_CMD_NONE  = 3'd0,
    BXT_CMD_FERST = 3'd1,
    BXT_CMD_BCRST = 3'd2,
    BXT_CMD_SYNC  = 3'd3,
    BXT_CMD_SNAP  = 3'd4,
    BXT_CMD_CAL   = 3'd5
  } bxt_cmd_e;
endpackage

// File: rtl/bxt_capture.sv
module bxt_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/bxt_bunch_counter.sv
module bxt_bunch_counter #(
  parameter int BX_W  = 12,
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bc_rst,
  input  logic [BX_W-1:0]  offset,
  input  logic [BX_W-1:0]  expected,
  output logic [BX_W-1:0]  bx,
  output logic [ERR_W-1:0] err_cnt,
  output logic [BX_W-1:0]  err_bx,
  output logic             mismatch
);
  localparam logic [BX_W-1:0]  BX_ONE  = 1;
  localparam logic [ERR_W-1:0] ERR_ONE = 1;
  localparam logic [ERR_W-1:0] ERR_TOP = '1;

  function automatic logic [BX_W-1:0] bx_step(input logic [BX_W-1:0] c);
    return c + BX_ONE;
  endfunction

  function automatic logic [ERR_W-1:0] err_bump(input logic [ERR_W-1:0] e);
    return (e == ERR_TOP) ? e : e + ERR_ONE;
  endfunction

  assign mismatch = bc_rst && (bx != expected);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bx <= '0;
    else if (bc_rst) bx <= offset;
    else             bx <= bx_step(bx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_cnt <= '0;
      err_bx  <= '0;
    end else if (mismatch) begin
      err_cnt <= err_bump(err_cnt);
      err_bx  <= bx;
    end
  end
endmodule

// File: rtl/bxt_clear_seq.sv
module bxt_clear_seq #(
  parameter int CLR_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic clearing
);
  localparam int CW = $clog2(CLR_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CLR_CYCLES);
  localparam logic [CW-1:0] C_ONE = 1;

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain <= '0;
    else if (start)           remain <= LOAD;
    else if (remain != '0)    remain <= remain - C_ONE;
  end

  assign clearing = (remain != '0);
endmodule

// File: rtl/bxt_fast_ctrl.sv
module bxt_fast_ctrl
  import bxt_pkg::*;
#(
  parameter int BX_W       = BXT_BX_W,
  parameter int TS_W       = BXT_TS_W,
  parameter int ERR_W      = BXT_ERR_W,
  parameter int CLR_CYCLES = BXT_CLR_LEN,
  parameter int SYNC_W     = BXT_SYNC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_fe_rst,
  input  logic              cmd_bc_rst,
  input  logic              cmd_sync,
  input  logic              cmd_snap,
  input  logic              cmd_cal,
  input  logic [BX_W-1:0]   cfg_offset,
  input  logic [BX_W-1:0]   cfg_expected,
  input  logic [SYNC_W-1:0] cfg_sync_word,
  output logic [BX_W-1:0]   bx_count,
  output logic [TS_W-1:0]   timestamp,
  output logic              buf_clear,
  output logic              clear_busy,
  output logic              sync_send,
  output logic [SYNC_W-1:0] sync_word,
  output logic              cal_pulse,
  output logic [ERR_W-1:0]  err_count,
  output logic [BX_W-1:0]   err_last_bx,
  output logic [BX_W-1:0]   snap_bx,
  output logic [ERR_W-1:0]  snap_err,
  output logic [BX_W-1:0]   snap_last_bx
);
  localparam int SNAP_W = 2 * BX_W + ERR_W;

  logic              bc_mismatch;
  logic              clearing;
  logic [SNAP_W-1:0] snap_d;
  logic [SNAP_W-1:0] snap_q;

  bxt_bunch_counter #(.BX_W(BX_W), .ERR_W(ERR_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .bc_rst   (cmd_bc_rst),
    .offset   (cfg_offset),
    .expected (cfg_expected),
    .bx       (bx_count),
    .err_cnt  (err_count),
    .err_bx   (err_last_bx),
    .mismatch (bc_mismatch)
  );

  assign timestamp = bx_count[TS_W-1:0];

  bxt_clear_seq #(.CLR_CYCLES(CLR_CYCLES)) u_clr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (cmd_fe_rst),
    .clearing (clearing)
  );

  assign buf_clear  = clearing;
  assign clear_busy = clearing;

  assign snap_d = {bx_count, err_count, err_last_bx};

  bxt_capture #(.W(SNAP_W)) u_snap (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (cmd_snap),
    .d     (snap_d),
    .q     (snap_q)
  );

  assign snap_bx      = snap_q[SNAP_W-1 -: BX_W];
  assign snap_err     = snap_q[BX_W +: ERR_W];
  assign snap_last_bx = snap_q[BX_W-1:0];

  bxt_capture #(.W(SYNC_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (cmd_sync),
    .d     (cfg_sync_word),
    .q     (sync_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_send <= 1'b0;
      cal_pulse <= 1'b0;
    end else begin
      sync_send <= cmd_sync;
      cal_pulse <= cmd_cal;
    end
  end
endmodule

// File: rtl/bxt_fast_ctrl_chk.sv
module bxt_fast_ctrl_chk #(
  parameter int BX_W       = 12,
  parameter int ERR_W      = 8,
  parameter int CLR_CYCLES = 64,
  parameter int SYNC_W     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_fe_rst,
  input logic              cmd_bc_rst,
  input logic              cmd_sync,
  input logic              cmd_snap,
  input logic              cmd_cal,
  input logic [BX_W-1:0]   cfg_offset,
  input logic [BX_W-1:0]   cfg_expected,
  input logic [SYNC_W-1:0] cfg_sync_word,
  input logic [BX_W-1:0]   bx_count,
  input logic              buf_clear,
  input logic              clear_busy,
  input logic              sync_send,
  input logic [SYNC_W-1:0] sync_word,
  input logic              cal_pulse,
  input logic [ERR_W-1:0]  err_count,
  input logic [BX_W-1:0]   err_last_bx,
  input logic [BX_W-1:0]   snap_bx,
  input logic [ERR_W-1:0]  snap_err,
  input logic [BX_W-1:0]   snap_last_bx,
  input logic              bc_mismatch
);
  localparam logic [BX_W-1:0]  BX_ONE  = 1;
  localparam logic [ERR_W-1:0] ERR_ONE = 1;
  localparam logic [ERR_W-1:0] ERR_TOP = '1;
  localparam int AW = $clog2(CLR_CYCLES + 1);
  localparam logic [AW-1:0] A_LAST = AW'(CLR_CYCLES);
  localparam logic [AW-1:0] A_ONE  = 1;

  logic [AW-1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             age <= '0;
    else if (cmd_fe_rst)                    age <= A_ONE;
    else if (age != '0 && age != A_LAST)    age <= age + A_ONE;
    else                                    age <= '0;
  end

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_bc_rst |=> bx_count == $past(bx_count) + BX_ONE);

  // R2
  preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_bc_rst |=> bx_count == $past(cfg_offset));

  // R3
  mismatch_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_mismatch && err_count != ERR_TOP) |=>
      (err_count == $past(err_count) + ERR_ONE) && (err_last_bx == $past(bx_count)));

  // R4
  aligned_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_bc_rst && bx_count == cfg_expected) |=> $stable(err_count) && $stable(err_last_bx));

  // R5
  err_hold_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == ERR_TOP) |=> err_count == ERR_TOP);

  // R7
  clear_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_clear == (age != '0)) && (clear_busy == buf_clear));

  // R8
  sync_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_sync |=> sync_send && sync_word == $past(cfg_sync_word));

  // R8
  sync_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_sync |=> !sync_send && $stable(sync_word));

  // R9
  snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_snap |=> snap_bx == $past(bx_count) && snap_err == $past(err_count)
                 && snap_last_bx == $past(err_last_bx));

  // R9
  snap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_snap |=> $stable(snap_bx) && $stable(snap_err) && $stable(snap_last_bx));

  // R10
  cal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_cal |=> cal_pulse);

  // R10
  cal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_cal |=> !cal_pulse);
endmodule

bind bxt_fast_ctrl bxt_fast_ctrl_chk #(
  .BX_W(BX_W), .ERR_W(ERR_W), .CLR_CYCLES(CLR_CYCLES), .SYNC_W(SYNC_W)
) u_chk (.*);

// File: tb/tb_bxt_fast_ctrl.sv
`timescale 1ns/1ps
module tb_bxt_fast_ctrl;
  localparam int ERR_W   = 3;
  localparam int ERR_MAX = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fe = 1'b0, bc = 1'b0, sy = 1'b0, sn = 1'b0, ca = 1'b0;
  logic [11:0] offset = '0, expected = '0;
  logic [31:0] pat = '0;

  logic [11:0]      bx_count, err_last_bx, snap_bx, snap_last_bx;
  logic [8:0]       timestamp;
  logic             buf_clear, clear_busy, sync_send, cal_pulse;
  logic [31:0]      sync_word;
  logic [ERR_W-1:0] err_count, snap_err;

  int n_chk = 0, n_fail = 0;
  int exp_bx = 0, exp_err = 0, exp_bad = 0;
  int s_bx = 0, s_err = 0, s_bad = 0;

  always #2.5 clk = ~clk;

  bxt_fast_ctrl #(.ERR_W(ERR_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_fe_rst(fe), .cmd_bc_rst(bc), .cmd_sync(sy), .cmd_snap(sn), .cmd_cal(ca),
    .cfg_offset(offset), .cfg_expected(expected), .cfg_sync_word(pat),
    .bx_count(bx_count), .timestamp(timestamp),
    .buf_clear(buf_clear), .clear_busy(clear_busy),
    .sync_send(sync_send), .sync_word(sync_word), .cal_pulse(cal_pulse),
    .err_count(err_count), .err_last_bx(err_last_bx),
    .snap_bx(snap_bx), .snap_err(snap_err), .snap_last_bx(snap_last_bx)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // model of count and error tally, updated from the strobes about to be clocked
  task automatic tick();
    if (sn) begin s_bx = exp_bx; s_err = exp_err; s_bad = exp_bad; end
    if (bc) begin
      if (exp_bx != int'(expected)) begin
        if (exp_err < ERR_MAX) exp_err++;
        exp_bad = exp_bx;
      end
      exp_bx = int'(offset);
    end else begin
      exp_bx = (exp_bx + 1) % 4096;
    end
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R11", "bx_count", 32'(bx_count), 0);
    check("R11", "err_count", 32'(err_count), 0);
    check("R11", "clear/sync/cal", {29'd0, buf_clear, sync_send, cal_pulse}, 0);
    check("R11", "snap_bx", 32'(snap_bx), 0);
    check("R11", "sync_word", sync_word, 0);
    rst_n = 1'b1;
    exp_bx = 0;
  endtask

  task automatic t_count();
    logic [11:0] prev;
    repeat (20) tick();
    check("R1", "count after 20", 32'(bx_count), 32'(exp_bx));
    prev = bx_count;
    tick();
    check("R1", "single step", 32'(bx_count), 32'(prev + 12'd1));
    check("R6", "timestamp", 32'(timestamp), 32'(exp_bx % 512));
  endtask

  task automatic t_preload_wrap();
    int e0;
    e0 = exp_err;
    expected = 12'(exp_bx);
    offset = 12'd4093;
    bc = 1'b1; tick(); bc = 1'b0;
    check("R2", "preload", 32'(bx_count), 4093);
    check("R4", "err on aligned reset", 32'(err_count), 32'(e0));
    check("R6", "timestamp at 0xFFD", 32'(timestamp), 32'h1FD);
    repeat (5) tick();
    check("R1", "wrap to 2", 32'(bx_count), 2);
    check("R6", "timestamp after wrap", 32'(timestamp), 2);
  endtask

  task automatic t_mismatch();
    int seen;
    expected = 12'h123;
    offset = 12'd7;
    repeat (3) tick();
    seen = exp_bx;
    bc = 1'b1; tick(); bc = 1'b0;
    check("R3", "err after mismatch", 32'(err_count), 1);
    check("R3", "last bad count", 32'(err_last_bx), 32'(seen));
    check("R2", "offset after mismatch", 32'(bx_count), 7);
  endtask

  task automatic t_saturate();
    expected = 12'hFFF;
    offset = 12'd0;
    for (int i = 0; i < 9; i++) begin
      bc = 1'b1; tick(); bc = 1'b0;
      tick();
    end
    check("R5", "tally saturated", 32'(err_count), ERR_MAX);
    check("R5", "model tally", 32'(exp_err), ERR_MAX);
  endtask

  task automatic t_clear();
    int n, bad_busy, e0;
    e0 = exp_err;
    check("R7", "idle before clear", {31'd0, buf_clear}, 0);
    fe = 1'b1; tick(); fe = 1'b0;
    n = 0; bad_busy = 0;
    while (buf_clear === 1'b1 && n < 200) begin
      if (clear_busy !== 1'b1) bad_busy++;
      n++; tick();
    end
    check("R7", "clear length", 32'(n), 64);
    check("R7", "busy follows clear", 32'(bad_busy), 0);
    check("R7", "count untouched", 32'(bx_count), 32'(exp_bx));
    check("R7", "tally untouched", 32'(err_count), 32'(e0));
    fe = 1'b1; tick(); fe = 1'b0;
    repeat (30) tick();
    fe = 1'b1; tick(); fe = 1'b0;
    n = 0;
    while (buf_clear === 1'b1 && n < 200) begin n++; tick(); end
    check("R7", "restart length", 32'(n), 64);
    check("R7", "busy low at end", {31'd0, clear_busy}, 0);
  endtask

  task automatic t_sync();
    pat = 32'hC3A5_0F96;
    sy = 1'b1; tick(); sy = 1'b0;
    check("R8", "sync_send high", {31'd0, sync_send}, 1);
    check("R8", "sync_word", sync_word, 32'hC3A5_0F96);
    pat = 32'h1234_5678;
    tick();
    check("R8", "sync_send single", {31'd0, sync_send}, 0);
    check("R8", "sync_word held", sync_word, 32'hC3A5_0F96);
  endtask

  task automatic t_snap();
    repeat (4) tick();
    sn = 1'b1; tick(); sn = 1'b0;
    check("R9", "snap_bx", 32'(snap_bx), 32'(s_bx));
    check("R9", "snap_err", 32'(snap_err), 32'(s_err));
    check("R9", "snap_last_bx", 32'(snap_last_bx), 32'(s_bad));
    expected = 12'd0; offset = 12'd55;
    bc = 1'b1; tick(); bc = 1'b0;
    repeat (6) tick();
    check("R9", "snap_bx held", 32'(snap_bx), 32'(s_bx));
    check("R9", "snap_last_bx held", 32'(snap_last_bx), 32'(s_bad));
  endtask

  task automatic t_cal();
    check("R10", "cal idle", {31'd0, cal_pulse}, 0);
    ca = 1'b1; tick(); ca = 1'b0;
    check("R10", "cal high", {31'd0, cal_pulse}, 1);
    tick();
    check("R10", "cal single", {31'd0, cal_pulse}, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_count();
    t_preload_wrap();
    t_mismatch();
    t_saturate();
    t_clear();
    t_sync();
    t_snap();
    t_cal();
    check("R1", "final count", 32'(bx_count), 32'(exp_bx));
    summary();
    $finish;
  end
endmodule